// File: doc/BRIEF.md
# Masked Permutation Round Sequencer

This block is the control state machine of an iterative permutation engine built from a fixed number of identical rounds. It accepts message-absorb and storage-clear requests while idle, starts a run on request, counts rounds, and strobes an update enable to the round datapath once per executed step. The datapath itself is outside the block; only its per-step enable, the absorb strobe and the storage wipe strobe leave the sequencer.

A compile-time option picks one of two round schedules. Unmasked, each round takes one cycle. Masked, each round is four steps: a first phase that waits until fresh randomness is signalled, then three second-phase cycles that always follow back to back. A multi-bit escalation input forces a permanent lock state from any state; only reset leaves it. Multi-bit control inputs use the 4-bit codes 4'b0110 for true and 4'b1001 for false. All outputs are registered, so every response appears in the cycle after the clock edge at which the input was sampled.

Top module: `perm_round_seq`

## Requirements
- R1: After synchronous reset, ready is 1 and absorb, wipe, step, done, err and locked are 0, with round_idx 0.
- R2: In the idle state, in_valid high produces an absorb pulse in the next cycle and keeps the block idle; it takes priority over clear and start sampled at the same edge, so no wipe pulse appears.
- R3: In the idle state without in_valid, clear_req equal to 4'b0110 produces a wipe pulse and keeps the block idle, even with start high; any other clear_req code (for example 4'b0111 or 4'b1001) produces no wipe.
- R4: Unmasked, a start sampled in idle is followed by exactly MAX_ROUND consecutive step pulses, one per round, with round_idx counting 1, 2, ... after each of the first MAX_ROUND-1 rounds; the last step coincides with done and ready.
- R5: Masked, the first phase of every round holds (no step pulse, round_idx and ready unchanged) until rnd_early or rnd_valid is high; either one alone lets it advance.
- R6: Masked, each round is four consecutive step pulses once the first phase advances; round_idx increments after the fourth, and after the fourth step of round MAX_ROUND-1 the block is idle with done high.
- R7: done is a pulse of exactly one cycle on the return to idle after the final round; round_idx holds MAX_ROUND-1 there and is 0 again in the cycle after the next start.
- R8: While a run is in progress ready is 0 and in_valid and clear_req produce no absorb and no wipe pulse.
- R9: Any esc code other than 4'b1001 sampled in any state makes locked and err 1 and ready 0 in the next cycle, with no absorb, wipe or step in that cycle; the lock persists with no strobes whatever the inputs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message word present; absorb it while idle |
| start | input | 1 | Begin a permutation run |
| clear_req | input | 4 | Multi-bit storage clear request |
| esc | input | 4 | Multi-bit escalation; anything but false locks the block |
| rnd_early | input | 1 | Randomness will be ready in time for phase two |
| rnd_valid | input | 1 | Randomness is ready now |
| absorb | output | 1 | Registered strobe: XOR the message into storage |
| wipe | output | 1 | Registered strobe: reset the storage |
| step | output | 1 | Registered strobe: apply one datapath step |
| ready | output | 1 | Block is idle and accepts requests |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | Error or lock state reached |
| locked | output | 1 | Permanent lock state |
| round_idx | output | $clog2(MAX_ROUND) | Current round counter |

## Verification
A state register stuck in or skipping a phase shows up at once as a missing or surplus step pulse, and a masked round of the wrong length shifts round_idx at the port within four cycles. A wrong counter or last-round compare changes the cycle in which done and ready rise, which the bench compares against the exact count of MAX_ROUND or 4*MAX_ROUND plus wait cycles. A priority error in idle appears in the single cycle after the request as the wrong strobe, and a lock that does not stick appears as a strobe or a high ready in the cycles after escalation.

// File: rtl/perm_seq_pkg.sv
package perm_seq_pkg;

  localparam int MBW = 4;
  localparam logic [MBW-1:0] MB_TRUE  = 4'b0110;
  localparam logic [MBW-1:0] MB_FALSE = 4'b1001;

  // 4-bit codes leave eight spare encodings that fall into the error state
  typedef enum logic [3:0] {
    ST_IDLE = 4'b0001,
    ST_RUN  = 4'b0010,
    ST_PH1  = 4'b0100,
    ST_P2A  = 4'b0111,
    ST_P2B  = 4'b1011,
    ST_P2C  = 4'b1101,
    ST_ERR  = 4'b1110,
    ST_LOCK = 4'b1000
  } seq_st_e;

  function automatic logic mb_true_strict(input logic [MBW-1:0] v);
    return v == MB_TRUE;
  endfunction

  function automatic logic mb_true_loose(input logic [MBW-1:0] v);
    return v != MB_FALSE;
  endfunction

  function automatic logic mb_false_loose(input logic [MBW-1:0] v);
    return v != MB_TRUE;
  endfunction

endpackage

// File: rtl/perm_seq_next.sv
module perm_seq_next
  import perm_seq_pkg::*;
#(
  parameter bit MASKED = 1'b1
) (
  input  seq_st_e        st,
  input  logic           in_valid,
  input  logic           start,
  input  logic [MBW-1:0] clear_req,
  input  logic [MBW-1:0] esc,
  input  logic           rnd_early,
  input  logic           rnd_valid,
  input  logic           last_rnd,
  output seq_st_e        st_nx,
  output logic           do_absorb,
  output logic           do_wipe,
  output logic           do_step,
  output logic           do_done,
  output logic           cnt_clr,
  output logic           cnt_inc
);

  logic wipe_req;

  always_comb begin
    st_nx     = st;
    do_absorb = 1'b0;
    wipe_req  = 1'b0;
    do_step   = 1'b0;
    do_done   = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;

    case (st)
      ST_IDLE: begin
        if (in_valid) begin
          do_absorb = 1'b1;
        end else if (mb_true_strict(clear_req)) begin
          wipe_req = 1'b1;
        end else if (start) begin
          cnt_clr = 1'b1;
          st_nx   = MASKED ? ST_PH1 : ST_RUN;
        end
      end

      ST_RUN: begin
        if (MASKED) begin
          st_nx = ST_ERR;
        end else begin
          do_step = 1'b1;
          if (last_rnd) begin
            do_done = 1'b1;
            st_nx   = ST_IDLE;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end

      ST_PH1: begin
        if (!MASKED) begin
          st_nx = ST_ERR;
        end else if (rnd_early || rnd_valid) begin
          do_step = 1'b1;
          st_nx   = ST_P2A;
        end
      end

      ST_P2A: begin
        if (!MASKED) begin
          st_nx = ST_ERR;
        end else begin
          do_step = 1'b1;
          st_nx   = ST_P2B;
        end
      end

      ST_P2B: begin
        if (!MASKED) begin
          st_nx = ST_ERR;
        end else begin
          do_step = 1'b1;
          st_nx   = ST_P2C;
        end
      end

      ST_P2C: begin
        if (!MASKED) begin
          st_nx = ST_ERR;
        end else begin
          do_step = 1'b1;
          if (last_rnd) begin
            do_done = 1'b1;
            st_nx   = ST_IDLE;
          end else begin
            cnt_inc = 1'b1;
            st_nx   = ST_PH1;
          end
        end
      end

      ST_ERR:  st_nx = ST_LOCK;
      ST_LOCK: st_nx = ST_LOCK;
      default: st_nx = ST_ERR;
    endcase

    if (mb_true_loose(esc)) begin
      st_nx     = ST_LOCK;
      do_absorb = 1'b0;
      wipe_req  = 1'b0;
      do_step   = 1'b0;
      do_done   = 1'b0;
      cnt_clr   = 1'b0;
      cnt_inc   = 1'b0;
    end
  end

  // storage wipe only while idle and the clear code is not a false code
  assign do_wipe = wipe_req && (st == ST_IDLE) && !mb_false_loose(clear_req);

endmodule

// File: rtl/perm_seq_rcnt.sv
module perm_seq_rcnt #(
  parameter int MAX_ROUND = 24,
  localparam int CW = (MAX_ROUND > 1) ? $clog2(MAX_ROUND) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          last
);

  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_ROUND - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == LAST_VAL);

endmodule

// File: rtl/perm_seq_oreg.sv
module perm_seq_oreg
  import perm_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  seq_st_e st_nx,
  input  logic    do_absorb,
  input  logic    do_wipe,
  input  logic    do_step,
  input  logic    do_done,
  output logic    absorb,
  output logic    wipe,
  output logic    step,
  output logic    done,
  output logic    ready,
  output logic    err,
  output logic    locked
);

  always_ff @(posedge clk) begin
    if (rst) begin
      absorb <= 1'b0;
      wipe   <= 1'b0;
      step   <= 1'b0;
      done   <= 1'b0;
      ready  <= 1'b1;
      err    <= 1'b0;
      locked <= 1'b0;
    end else begin
      absorb <= do_absorb;
      wipe   <= do_wipe;
      step   <= do_step;
      done   <= do_done;
      ready  <= (st_nx == ST_IDLE);
      err    <= (st_nx == ST_ERR) || (st_nx == ST_LOCK);
      locked <= (st_nx == ST_LOCK);
    end
  end

endmodule

// File: rtl/perm_round_seq.sv
module perm_round_seq
  import perm_seq_pkg::*;
#(
  parameter int MAX_ROUND = 24,
  parameter bit MASKED    = 1'b1,
  localparam int CW = (MAX_ROUND > 1) ? $clog2(MAX_ROUND) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          start,
  input  logic [3:0]    clear_req,
  input  logic [3:0]    esc,
  input  logic          rnd_early,
  input  logic          rnd_valid,
  output logic          absorb,
  output logic          wipe,
  output logic          step,
  output logic          ready,
  output logic          done,
  output logic          err,
  output logic          locked,
  output logic [CW-1:0] round_idx
);

  seq_st_e st_q;
  seq_st_e st_nx;
  logic    do_absorb;
  logic    do_wipe;
  logic    do_step;
  logic    do_done;
  logic    cnt_clr;
  logic    cnt_inc;
  logic    last_rnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_nx;
    end
  end

  perm_seq_next #(
    .MASKED (MASKED)
  ) u_next (
    .st        (st_q),
    .in_valid  (in_valid),
    .start     (start),
    .clear_req (clear_req),
    .esc       (esc),
    .rnd_early (rnd_early),
    .rnd_valid (rnd_valid),
    .last_rnd  (last_rnd),
    .st_nx     (st_nx),
    .do_absorb (do_absorb),
    .do_wipe   (do_wipe),
    .do_step   (do_step),
    .do_done   (do_done),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc)
  );

  perm_seq_rcnt #(
    .MAX_ROUND (MAX_ROUND)
  ) u_rcnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .cnt  (round_idx),
    .last (last_rnd)
  );

  perm_seq_oreg u_oreg (
    .clk       (clk),
    .rst       (rst),
    .st_nx     (st_nx),
    .do_absorb (do_absorb),
    .do_wipe   (do_wipe),
    .do_step   (do_step),
    .do_done   (do_done),
    .absorb    (absorb),
    .wipe      (wipe),
    .step      (step),
    .done      (done),
    .ready     (ready),
    .err       (err),
    .locked    (locked)
  );

endmodule

// File: rtl/perm_round_seq_chk.sv
module perm_round_seq_chk #(
  parameter int MAX_ROUND = 24,
  localparam int CW = (MAX_ROUND > 1) ? $clog2(MAX_ROUND) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    esc,
  input logic          absorb,
  input logic          wipe,
  input logic          step,
  input logic          ready,
  input logic          done,
  input logic          err,
  input logic          locked,
  input logic [CW-1:0] round_idx
);

  AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst) (absorb || wipe) |-> ready); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(absorb && wipe)); // R3
  AST_BUSY_QUIET:  assert property (@(posedge clk) disable iff (rst) !ready |-> !(absorb || wipe)); // R8
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (rst) done |-> (ready && step)); // R4
  AST_RND_RANGE:   assert property (@(posedge clk) disable iff (rst) round_idx <= CW'(MAX_ROUND - 1)); // R6
  AST_ESC_LOCK:    assert property (@(posedge clk) disable iff (rst) (esc != 4'b1001) |=> (locked && !step)); // R9
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst) locked |=> locked); // R9
  AST_LOCK_ERR:    assert property (@(posedge clk) disable iff (rst) locked |-> (err && !ready)); // R9

endmodule

bind perm_round_seq perm_round_seq_chk #(
  .MAX_ROUND (MAX_ROUND)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .esc       (esc),
  .absorb    (absorb),
  .wipe      (wipe),
  .step      (step),
  .ready     (ready),
  .done      (done),
  .err       (err),
  .locked    (locked),
  .round_idx (round_idx)
);

// File: tb/perm_round_seq_bench.sv
`timescale 1ns/1ps
module perm_round_seq_bench;

  localparam int NR = 24;
  localparam int CW = $clog2(NR);
  localparam logic [3:0] TRUE_C  = 4'b0110;
  localparam logic [3:0] FALSE_C = 4'b1001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic start = 1'b0;
  logic [3:0] clear_req = FALSE_C;
  logic [3:0] esc = FALSE_C;
  logic rnd_early = 1'b0;
  logic rnd_valid = 1'b0;

  logic m_absorb, m_wipe, m_step, m_ready, m_done, m_err, m_locked;
  logic p_absorb, p_wipe, p_step, p_ready, p_done, p_err, p_locked;
  logic [CW-1:0] m_round, p_round;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  perm_round_seq #(.MAX_ROUND(NR), .MASKED(1'b1)) u_perm_round_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .start(start),
    .clear_req(clear_req), .esc(esc), .rnd_early(rnd_early), .rnd_valid(rnd_valid),
    .absorb(m_absorb), .wipe(m_wipe), .step(m_step), .ready(m_ready),
    .done(m_done), .err(m_err), .locked(m_locked), .round_idx(m_round)
  );

  perm_round_seq #(.MAX_ROUND(NR), .MASKED(1'b0)) u_perm_round_seq_plain (
    .clk(clk), .rst(rst), .in_valid(in_valid), .start(start),
    .clear_req(clear_req), .esc(esc), .rnd_early(rnd_early), .rnd_valid(rnd_valid),
    .absorb(p_absorb), .wipe(p_wipe), .step(p_step), .ready(p_ready),
    .done(p_done), .err(p_err), .locked(p_locked), .round_idx(p_round)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    in_valid  = 1'b0;
    start     = 1'b0;
    clear_req = FALSE_C;
    esc       = FALSE_C;
    rnd_early = 1'b0;
    rnd_valid = 1'b0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    chk("R1 ready m", int'(m_ready), 1);
    chk("R1 ready p", int'(p_ready), 1);
    chk("R1 strobes m", int'({m_absorb, m_wipe, m_step, m_done, m_err, m_locked}), 0);
    chk("R1 strobes p", int'({p_absorb, p_wipe, p_step, p_done, p_err, p_locked}), 0);
    chk("R1 round m", int'(m_round), 0);
    chk("R1 round p", int'(p_round), 0);
  endtask

  task automatic t_absorb();
    in_valid = 1'b1; start = 1'b1; clear_req = TRUE_C;
    tick();
    idle_inputs();
    chk("R2 absorb m", int'(m_absorb), 1);
    chk("R2 absorb p", int'(p_absorb), 1);
    chk("R2 no wipe", int'(m_wipe | p_wipe), 0);
    chk("R2 still idle", int'(m_ready & p_ready), 1);
    tick();
    chk("R2 absorb ends", int'(m_absorb | p_absorb), 0);
    chk("R2 no run", int'(m_ready & p_ready), 1);
  endtask

  task automatic t_clear();
    clear_req = TRUE_C; start = 1'b1;
    tick();
    idle_inputs();
    chk("R3 wipe m", int'(m_wipe), 1);
    chk("R3 wipe p", int'(p_wipe), 1);
    chk("R3 no absorb", int'(m_absorb | p_absorb), 0);
    chk("R3 stays idle", int'(m_ready & p_ready), 1);
    clear_req = 4'b0111;
    tick();
    chk("R3 code 0111 no wipe", int'(m_wipe | p_wipe), 0);
    clear_req = FALSE_C;
    tick();
    chk("R3 false code no wipe", int'(m_wipe | p_wipe), 0);
    chk("R3 idle after", int'(m_ready & p_ready), 1);
  endtask

  task automatic t_plain_run();
    start = 1'b1;
    tick();
    start = 1'b0;
    in_valid = 1'b1; clear_req = TRUE_C;
    chk("R8 busy m", int'(m_ready), 0);
    chk("R8 busy p", int'(p_ready), 0);
    for (int k = 1; k <= NR; k++) begin
      tick();
      chk("R4 step p", int'(p_step), 1);
      if (k < NR) begin
        chk("R4 round p", int'(p_round), k);
        chk("R8 ready p", int'(p_ready), 0);
        chk("R7 no early done", int'(p_done), 0);
      end else begin
        chk("R4 done p", int'(p_done), 1);
        chk("R4 ready p", int'(p_ready), 1);
        chk("R7 round held", int'(p_round), NR - 1);
      end
      chk("R5 wait step m", int'(m_step), 0);
      chk("R5 wait ready m", int'(m_ready), 0);
      chk("R5 wait round m", int'(m_round), 0);
      if (k <= 10) begin
        chk("R8 no absorb", int'(m_absorb | p_absorb), 0);
        chk("R8 no wipe", int'(m_wipe | p_wipe), 0);
      end
      if (k == 10) begin
        in_valid = 1'b0; clear_req = FALSE_C;
      end
    end
    tick();
    chk("R7 done one cycle", int'(p_done), 0);
    chk("R4 step ends", int'(p_step), 0);
  endtask

  task automatic t_masked_run();
    for (int r = 0; r < NR; r++) begin
      if (r == 5) begin
        for (int w = 0; w < 3; w++) begin
          tick();
          chk("R5 hold step", int'(m_step), 0);
          chk("R5 hold round", int'(m_round), 5);
          chk("R5 hold ready", int'(m_ready), 0);
        end
      end
      if (r % 2 == 1) rnd_valid = 1'b1;
      else            rnd_early = 1'b1;
      tick();
      rnd_valid = 1'b0; rnd_early = 1'b0;
      chk("R5 advance step", int'(m_step), 1);
      for (int j = 1; j <= 3; j++) begin
        tick();
        chk("R6 phase2 step", int'(m_step), 1);
        if (j < 3) begin
          chk("R6 round mid", int'(m_round), r);
          chk("R6 busy", int'(m_ready), 0);
        end else if (r < NR - 1) begin
          chk("R6 round inc", int'(m_round), r + 1);
          chk("R6 no done", int'(m_done), 0);
        end else begin
          chk("R6 done m", int'(m_done), 1);
          chk("R6 ready m", int'(m_ready), 1);
          chk("R7 round held m", int'(m_round), NR - 1);
        end
      end
    end
    tick();
    chk("R7 done one cycle m", int'(m_done), 0);
    chk("R6 step ends m", int'(m_step), 0);
  endtask

  task automatic t_escalate_run();
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R7 restart round m", int'(m_round), 0);
    chk("R7 restart round p", int'(p_round), 0);
    tick(); tick(); tick();
    chk("R4 round p mid", int'(p_round), 3);
    esc = 4'b0000;
    tick();
    esc = FALSE_C;
    chk("R9 locked m", int'(m_locked & m_err), 1);
    chk("R9 locked p", int'(p_locked & p_err), 1);
    chk("R9 not ready", int'(m_ready | p_ready), 0);
    chk("R9 no step", int'(m_step | p_step), 0);
    in_valid = 1'b1; start = 1'b1; clear_req = TRUE_C; rnd_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R9 sticky", int'(m_locked & p_locked), 1);
      chk("R9 quiet", int'({m_absorb, m_wipe, m_step, p_absorb, p_wipe, p_step}), 0);
    end
    idle_inputs();
  endtask

  task automatic t_escalate_idle();
    esc = TRUE_C; in_valid = 1'b1;
    tick();
    idle_inputs();
    chk("R9 idle esc lock", int'(m_locked & p_locked), 1);
    chk("R9 esc beats absorb", int'(m_absorb | p_absorb), 0);
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_absorb();
    t_clear();
    t_plain_run();
    t_masked_run();
    t_escalate_run();
    t_reset();
    t_escalate_idle();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule